// File: doc/BRIEF.md
# Programmable 50% Duty Output Clock Divider

This block divides a fast clock, taken from a VCO, by 2, 4 or 5 as chosen by a 3-bit code. Every ratio gives a square wave with equal high and low times. For the odd ratio this holds too: the high phase ends on a falling edge of the fast clock. The divided clock feeds two output channels. Each channel has its own enable, which is synchronised and applied only while the divided clock is low. A third output carries a gated copy of a separate reference clock, with its own enable.

A new divide code is picked up only when the current output period ends. A change of code therefore never produces a short pulse. The analog output drivers, the VCO and the PLL loop are outside the block.

Top module: `outdiv_top`

## Requirements
- R1: Code 3'b001 gives an output period of 2 fast-clock cycles, high for 1 cycle and low for 1 cycle.
- R2: Code 3'b011 gives an output period of 4 fast-clock cycles, high for 2 and low for 2.
- R3: Code 3'b100 gives an output period of 5 fast-clock cycles. The output rises on a fast rising edge and stays high for exactly 2.5 cycles, so it falls on a fast falling edge.
- R4: Codes 3'b000, 3'b010, 3'b101, 3'b110 and 3'b111 divide by 2, the same as 3'b001.
- R5: The code is sampled only at the fast rising edge that ends an output period. The period in progress completes at the old ratio, and the first period at the new ratio starts with a rising edge of the output.
- R6: The channel A enable passes through two fast rising edges. It is then applied at the first fast falling edge at which the divided clock is low. While the applied enable is 0, out_a_o is held low, and no output pulse is ever shortened.
- R7: The channel B enable follows the same rules as R6 and acts independently of channel A.
- R8: ref_o equals ref_clk_i while the reference enable is applied, and is low otherwise. The enable passes through two ref_clk_i rising edges and is applied at the following ref_clk_i falling edge.
- R9: While rst_ni is low, all three outputs are low and all applied enables are 0. After release, the first fast rising edge starts an output period using the code present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock to be divided |
| ref_clk_i | input | 1 | Reference clock copied to ref_o |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 3 | Divide ratio code |
| en_a_i | input | 1 | Channel A enable (asynchronous) |
| en_b_i | input | 1 | Channel B enable (asynchronous) |
| ref_en_i | input | 1 | Reference copy enable (asynchronous) |
| out_a_o | output | 1 | Gated divided clock, channel A |
| out_b_o | output | 1 | Gated divided clock, channel B |
| ref_o | output | 1 | Gated reference clock |

## Verification
The hardest cases to reach are an enable that arrives during the half-cycle tail of a divide-by-5 high phase, and a code change that lands at an arbitrary point inside a period. The stimulus reaches both with sweeps. An enable is toggled with hold lengths from 3 to 9 cycles, and the code is switched between 2, 4 and 5 with hold lengths from 1 to 6 cycles. Over the sweep, each event falls at every phase of the output period. A behavioural model predicts both output levels in every fast cycle, one in each half. The bench checks each prediction at both half-cycle points.

// File: rtl/outdiv_pkg.sv
`timescale 1ns/1ps
package outdiv_pkg;
  localparam int unsigned DIV_CODE_W  = 3;
  localparam int unsigned DIV_CNT_W   = 3;
  localparam int unsigned RST_RATIO   = 2;
  localparam logic [DIV_CODE_W-1:0] CODE_DIV4 = 3'b011;
  localparam logic [DIV_CODE_W-1:0] CODE_DIV5 = 3'b100;

  // anything not listed falls back to divide-by-2
  function automatic int unsigned ratio_of(logic [DIV_CODE_W-1:0] code);
    case (code)
      CODE_DIV4: return 4;
      CODE_DIV5: return 5;
      default:   return RST_RATIO;
    endcase
  endfunction
endpackage

// File: rtl/outdiv_core.sv
`timescale 1ns/1ps
module outdiv_core
  import outdiv_pkg::*;
#(
  parameter int unsigned CODE_W = DIV_CODE_W,
  parameter int unsigned CNT_W  = DIV_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_clk_o,
  output logic [CNT_W-1:0]  ratio_o
);
  localparam logic [CNT_W-1:0] RST_R = CNT_W'(RST_RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic             half_q, half_d, neg_q, wrap;

  assign wrap    = (cnt_q == ratio_q - CNT_W'(1));
  assign ratio_d = wrap ? CNT_W'(ratio_of(code_i)) : ratio_q;
  assign cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign half_d  = cnt_d < (ratio_d >> 1);

  // reset parks the counter on a boundary so the first edge loads the code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= RST_R - CNT_W'(1);
      ratio_q <= RST_R;
      half_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      half_q  <= half_d;
    end
  end

  // half-cycle extension, odd ratios only
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= half_q & ratio_q[0];
  end

  assign div_clk_o = half_q | neg_q;
  assign ratio_o   = ratio_q;
endmodule

// File: rtl/outdiv_gate.sv
`timescale 1ns/1ps
module outdiv_gate #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          WAIT_LOW    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic src_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
  end

  generate
    if (WAIT_LOW) begin : g_wait_low
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     en_q <= 1'b0;
        else if (!src_i) en_q <= sync_q[SYNC_STAGES-1];
      end
    end else begin : g_direct
      // src is the clock itself: it is low right after this edge
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= sync_q[SYNC_STAGES-1];
      end
    end
  endgenerate

  assign clk_o = src_i & en_q;
endmodule

// File: rtl/outdiv_top.sv
`timescale 1ns/1ps
module outdiv_top
  import outdiv_pkg::*;
#(
  parameter int unsigned CODE_W      = DIV_CODE_W,
  parameter int unsigned CNT_W       = DIV_CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  input  logic              ref_en_i,
  output logic              out_a_o,
  output logic              out_b_o,
  output logic              ref_o
);
  localparam int unsigned NUM_CH = 2;

  logic             div_clk;
  logic [CNT_W-1:0] ratio;
  logic [NUM_CH-1:0] ch_en, ch_out;

  outdiv_core #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (div_code_i),
    .div_clk_o (div_clk),
    .ratio_o   (ratio)
  );

  assign ch_en = {en_b_i, en_a_i};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    outdiv_gate #(.SYNC_STAGES(SYNC_STAGES), .WAIT_LOW(1'b1)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en[g]),
      .src_i  (div_clk),
      .clk_o  (ch_out[g])
    );
  end

  outdiv_gate #(.SYNC_STAGES(SYNC_STAGES), .WAIT_LOW(1'b0)) u_ref_gate (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .en_i   (ref_en_i),
    .src_i  (ref_clk_i),
    .clk_o  (ref_o)
  );

  assign out_a_o = ch_out[0];
  assign out_b_o = ch_out[1];
endmodule

// File: rtl/outdiv_chk.sv
`timescale 1ns/1ps
module outdiv_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_a_i,
  input logic             en_b_i,
  input logic             out_a_o,
  input logic             out_b_o,
  input logic             ref_o,
  input logic             div_clk,
  input logic [CNT_W-1:0] ratio
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!out_a_o && !out_b_o && !ref_o); // R9
    end
  end

  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ratio == CNT_W'(2) && $past(ratio) == CNT_W'(2)) |-> (div_clk != $past(div_clk))); // R1

  AST_RATIO_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio == CNT_W'(2) || ratio == CNT_W'(4) || ratio == CNT_W'(5))); // R4

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio != $past(ratio)) |-> (div_clk && !$past(div_clk))); // R5

  AST_A_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 8) && !en_a_i && !$past(en_a_i, 1) && !$past(en_a_i, 2) && !$past(en_a_i, 3)
     && !$past(en_a_i, 4) && !$past(en_a_i, 5) && !$past(en_a_i, 6) && !$past(en_a_i, 7))
    |-> !out_a_o); // R6

  AST_B_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 8) && !en_b_i && !$past(en_b_i, 1) && !$past(en_b_i, 2) && !$past(en_b_i, 3)
     && !$past(en_b_i, 4) && !$past(en_b_i, 5) && !$past(en_b_i, 6) && !$past(en_b_i, 7))
    |-> !out_b_o); // R7
endmodule

bind outdiv_top outdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_a_i  (en_a_i),
  .en_b_i  (en_b_i),
  .out_a_o (out_a_o),
  .out_b_o (out_b_o),
  .ref_o   (ref_o),
  .div_clk (div_clk),
  .ratio   (ratio)
);

// File: tb/outdiv_top_tb_top.sv
`timescale 1ns/1ps
module outdiv_top_tb_top;
  logic       clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic [2:0] code = 3'b001;
  logic       en_a = 1'b1, en_b = 1'b1, ref_en = 1'b0;
  logic       out_a, out_b, ref_out;

  int    checks = 0, bad = 0;
  string cur_req = "R9";

  // behavioural model state
  int m_cnt, m_ratio;
  bit m_run;
  bit sa1, sa2, ea, sb1, sb2, eb, rs1, rs2, er;

  outdiv_top dut_i (
    .clk_i      (clk),
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_n),
    .div_code_i (code),
    .en_a_i     (en_a),
    .en_b_i     (en_b),
    .ref_en_i   (ref_en),
    .out_a_o    (out_a),
    .out_b_o    (out_b),
    .ref_o      (ref_out)
  );

  function automatic int ratio_for(logic [2:0] c);
    case (c)
      3'b011:  return 4;
      3'b100:  return 5;
      default: return 2;
    endcase
  endfunction

  // high time is ceil(r/2) cycles in first halves, floor(r/2) in second halves
  function automatic bit exp_div(bit first);
    if (!m_run) return 1'b0;
    return first ? (m_cnt < (m_ratio + 1) / 2) : (m_cnt < m_ratio / 2);
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic sample(bit first);
    bit d;
    d = exp_div(first);
    check(cur_req, "out_a", out_a, d & ea);
    check(cur_req, "out_b", out_b, d & eb);
    check(cur_req, "ref", ref_out, ref_clk & er);
  endtask

  task automatic model_reset();
    m_cnt = 1; m_ratio = 2; m_run = 1'b0;
    sa1 = 0; sa2 = 0; ea = 0; sb1 = 0; sb2 = 0; eb = 0;
    rs1 = 0; rs2 = 0; er = 0;
  endtask

  // one fast cycle: entry and exit 1 ns before the rising edge
  task automatic tick();
    if (!rst_n) model_reset();
    #1 clk = 1'b1;
    if (rst_n) begin
      sa2 = sa1; sa1 = en_a;
      sb2 = sb1; sb1 = en_b;
      if (m_cnt == m_ratio - 1) begin
        m_cnt = 0;
        m_ratio = ratio_for(code);
      end else begin
        m_cnt++;
      end
      m_run = 1'b1;
    end
    #0.5 ref_clk = ~ref_clk;
    if (rst_n) begin
      if (ref_clk) begin rs2 = rs1; rs1 = ref_en; end
      else er = rs2;
    end
    #0.5 sample(1'b1);
    #1 clk = 1'b0;
    if (rst_n && !exp_div(1'b1)) begin
      ea = sa2;
      eb = sb2;
    end
    #1 sample(1'b0);
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    model_reset();
    cur_req = "R9"; run(3);
    rst_n = 1'b1; run(6);
    cur_req = "R1"; run(20);
    code = 3'b011; cur_req = "R5"; run(6);
    cur_req = "R2"; run(20);
    code = 3'b100; cur_req = "R5"; run(6);
    cur_req = "R3"; run(30);
    cur_req = "R4";
    code = 3'b000; run(12);
    code = 3'b010; run(12);
    code = 3'b101; run(12);
    code = 3'b110; run(12);
    code = 3'b111; run(12);
    // code change swept across period phases
    cur_req = "R5";
    for (int k = 1; k < 7; k++) begin
      code = (k % 3 == 0) ? 3'b001 : ((k % 3 == 1) ? 3'b100 : 3'b011);
      run(k);
    end
    code = 3'b100; run(10);
    // enable sweep at odd ratio, hitting the half-cycle tail
    cur_req = "R6";
    for (int k = 3; k < 10; k++) begin
      en_a = ~en_a;
      run(k);
    end
    en_a = 1'b0; run(20);
    en_a = 1'b1; run(15);
    cur_req = "R7";
    en_b = 1'b0; run(20);
    for (int k = 3; k < 8; k++) begin
      en_b = ~en_b;
      run(k);
    end
    en_b = 1'b1; code = 3'b011; run(12);
    cur_req = "R8";
    ref_en = 1'b1; run(20);
    ref_en = 1'b0; run(12);
    ref_en = 1'b1; run(9);
    // reset in mid-run
    cur_req = "R9";
    rst_n = 1'b0; run(3);
    code = 3'b100; rst_n = 1'b1; run(15);
    summary();
    $finish;
  end
endmodule